// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This block keeps a 64-bit supervisor timer compare value and checks it against a free-running 64-bit time input. From that check it derives the supervisor timer interrupt pending bit. A timer enable bit gates the check. The enable bit lives in a machine environment configuration register that the block also holds. Apart from the enable bit, that register has one writable bit, the I/O-fence bit, and every other bit of it reads as zero.

Software reaches both registers through a simple CSR port. The port carries a request, write enable, 12-bit address, write data and the privilege level of the access, and it returns read data and an illegal-access flag in the same cycle. With 64-bit registers each register sits at one address. With 32-bit registers each register is split into a low half and a high half at two addresses. When the timer enable is off, the pending bit is not driven by the compare. Instead it keeps a value that software loads through a separate input.

Top module: `stimer_cmp`

## Requirements
- R1: While reset is asserted, the pending bit is 0, the compare register holds all ones and the configuration register reads 0.
- R2: With XLEN=64, a machine-mode access to 0x14D reads or writes all 64 compare bits in one access.
- R3: With XLEN=32, 0x14D holds compare bits 31..0 and 0x15D holds bits 63..32. A write to one half leaves the other half unchanged.
- R4: The configuration register is at 0x30A. With XLEN=32 its upper half is at 0x31A. Bit 63 is the timer enable and is writable when HAS_TCE=1. Bit 0 is the I/O-fence bit and is writable when FIOM_WR=1. All other bits, and any bit that is not writable, read as 0.
- R5: While the timer enable is 1, the pending output one cycle later equals (compare <= time), unsigned. So lowering or raising the compare sets or clears the bit with no acknowledge.
- R6: While the timer enable is 0, the pending output keeps its value, except when sti_sw_we_i is high; then it takes sti_sw_val_i on the next cycle. While the enable is 1, sti_sw_we_i has no effect.
- R7: An access is allowed in two cases: in machine mode (priv code 3), or in supervisor mode (priv code 1) to a compare address when both the timer enable and tm_cnt_en_i are 1. Every other access to an owned address is illegal, including every access to the configuration register from supervisor mode, every access with priv code 0 (user) and every access with the reserved code 2.
- R8: On an illegal access, csr_illegal_o is 1 in the same cycle, csr_rdata_o is 0, and no register changes.
- R9: With XLEN=64, addresses 0x15D and 0x31A are not owned by the block. An access to either raises no error, reads 0 and changes nothing.
- R10: An access to any address the block does not own raises no error, reads 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| time_i | input | 64 | Free-running machine time |
| csr_req_i | input | 1 | CSR access request |
| csr_we_i | input | 1 | Access is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | Write data |
| csr_priv_i | input | 2 | Privilege of the access (0 user, 1 supervisor, 3 machine) |
| tm_cnt_en_i | input | 1 | Time bit of the machine counter-enable register |
| sti_sw_we_i | input | 1 | Software load of the pending bit |
| sti_sw_val_i | input | 1 | Value loaded into the pending bit |
| csr_rdata_o | output | XLEN | Read data, 0 unless the access is legal |
| csr_illegal_o | output | 1 | Illegal access, same cycle |
| sti_pend_o | output | 1 | Supervisor timer interrupt pending |

## Verification
The bench builds two instances side by side and drives both with the same stimulus. The first uses XLEN=64 with the I/O-fence bit writable. The second uses XLEN=32 with the I/O-fence bit fixed at zero. This one setup covers several cases at once. It covers the split halves at 0x15D and 0x31A, and shows that the same addresses are unowned in the wide build. It also shows the enable bit landing through the high half. Finally, it covers a configuration bit that reads as zero however it is written.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam int CMP_W  = 64;
  localparam int ADDR_W = 12;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_M = 2'd3
  } priv_e;

  localparam logic [ADDR_W-1:0] A_CMP_LO = 12'h14D;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 12'h15D;
  localparam logic [ADDR_W-1:0] A_ENV_LO = 12'h30A;
  localparam logic [ADDR_W-1:0] A_ENV_HI = 12'h31A;

  typedef struct packed {
    logic cmp_lo;
    logic cmp_hi;
    logic env_lo;
    logic env_hi;
  } csr_sel_t;
endpackage

// File: rtl/stc_csr_decode.sv
module stc_csr_decode
  import stc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        priv_i,
  input  logic              tce_i,
  input  logic              cnt_tm_i,
  output csr_sel_t          sel_o,
  output logic              owned_o,
  output logic              ok_o,
  output logic              illegal_o,
  output csr_sel_t          wr_o
);
  localparam bit NARROW = XLEN < CMP_W;

  logic is_cmp, allowed;

  always_comb begin
    sel_o.cmp_lo = addr_i == A_CMP_LO;
    sel_o.cmp_hi = NARROW && (addr_i == A_CMP_HI);
    sel_o.env_lo = addr_i == A_ENV_LO;
    sel_o.env_hi = NARROW && (addr_i == A_ENV_HI);
  end

  assign owned_o = |sel_o;
  assign is_cmp  = sel_o.cmp_lo | sel_o.cmp_hi;

  always_comb begin
    unique case (priv_i)
      PRIV_M:  allowed = 1'b1;
      PRIV_S:  allowed = is_cmp & tce_i & cnt_tm_i;
      default: allowed = 1'b0;
    endcase
  end

  assign ok_o      = req_i & owned_o & allowed;
  assign illegal_o = req_i & owned_o & ~allowed;
  assign wr_o      = (ok_o & we_i) ? sel_o : '0;
endmodule

// File: rtl/stc_cmp_reg.sv
module stc_cmp_reg
  import stc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [XLEN-1:0]  wdata_i,
  output logic [CMP_W-1:0] cmp_o
);
  localparam int HALF = CMP_W / 2;

  if (XLEN >= CMP_W) begin : g_full
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                cmp_o <= '1;
      else if (wr_lo_i | wr_hi_i) cmp_o <= wdata_i[CMP_W-1:0];
    end
  end else begin : g_split
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cmp_o[HALF-1:0] <= '1;
      else if (wr_lo_i) cmp_o[HALF-1:0] <= wdata_i[HALF-1:0];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cmp_o[CMP_W-1:HALF] <= '1;
      else if (wr_hi_i) cmp_o[CMP_W-1:HALF] <= wdata_i[HALF-1:0];
    end
  end
endmodule

// File: rtl/stc_envcfg.sv
module stc_envcfg
  import stc_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit HAS_TCE = 1'b1,
  parameter bit FIOM_WR = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic             wbit_lsb_i,
  input  logic             wbit_msb_i,
  output logic             tce_o,
  output logic [CMP_W-1:0] env_o
);
  localparam bit NARROW = XLEN < CMP_W;

  logic fiom_q, tce_we;

  // enable bit lives in whichever access carries bit 63
  assign tce_we = NARROW ? wr_hi_i : wr_lo_i;

  if (HAS_TCE) begin : g_tce
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     tce_o <= 1'b0;
      else if (tce_we) tce_o <= wbit_msb_i;
    end
  end else begin : g_no_tce
    assign tce_o = 1'b0;
  end

  if (FIOM_WR) begin : g_fiom
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      fiom_q <= 1'b0;
      else if (wr_lo_i) fiom_q <= wbit_lsb_i;
    end
  end else begin : g_no_fiom
    assign fiom_q = 1'b0;
  end

  assign env_o = {tce_o, {(CMP_W-2){1'b0}}, fiom_q};
endmodule

// File: rtl/stc_pend.sv
module stc_pend
  import stc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMP_W-1:0] cmp_i,
  input  logic [CMP_W-1:0] time_i,
  input  logic             tce_i,
  input  logic             sw_we_i,
  input  logic             sw_val_i,
  output logic             pend_o
);
  logic due;

  assign due = cmp_i <= time_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_o <= 1'b0;
    else if (tce_i)   pend_o <= due;
    else if (sw_we_i) pend_o <= sw_val_i;
  end
endmodule

// File: rtl/stimer_cmp.sv
module stimer_cmp
  import stc_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter bit HAS_TCE = 1'b1,
  parameter bit FIOM_WR = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CMP_W-1:0]  time_i,
  input  logic              csr_req_i,
  input  logic              csr_we_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  input  logic [1:0]        csr_priv_i,
  input  logic              tm_cnt_en_i,
  input  logic              sti_sw_we_i,
  input  logic              sti_sw_val_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              csr_illegal_o,
  output logic              sti_pend_o
);
  csr_sel_t         sel, wr;
  logic             owned, ok, tce;
  logic [CMP_W-1:0] cmp_q, env_val;

  stc_csr_decode #(.XLEN(XLEN)) u_dec (
    .req_i     (csr_req_i),
    .we_i      (csr_we_i),
    .addr_i    (csr_addr_i),
    .priv_i    (csr_priv_i),
    .tce_i     (tce),
    .cnt_tm_i  (tm_cnt_en_i),
    .sel_o     (sel),
    .owned_o   (owned),
    .ok_o      (ok),
    .illegal_o (csr_illegal_o),
    .wr_o      (wr)
  );

  stc_cmp_reg #(.XLEN(XLEN)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (wr.cmp_lo),
    .wr_hi_i (wr.cmp_hi),
    .wdata_i (csr_wdata_i),
    .cmp_o   (cmp_q)
  );

  stc_envcfg #(.XLEN(XLEN), .HAS_TCE(HAS_TCE), .FIOM_WR(FIOM_WR)) u_env (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_lo_i    (wr.env_lo),
    .wr_hi_i    (wr.env_hi),
    .wbit_lsb_i (csr_wdata_i[0]),
    .wbit_msb_i (csr_wdata_i[XLEN-1]),
    .tce_o      (tce),
    .env_o      (env_val)
  );

  stc_pend u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmp_i    (cmp_q),
    .time_i   (time_i),
    .tce_i    (tce),
    .sw_we_i  (sti_sw_we_i),
    .sw_val_i (sti_sw_val_i),
    .pend_o   (sti_pend_o)
  );

  always_comb begin
    csr_rdata_o = '0;
    if (ok) begin
      if (sel.cmp_lo) csr_rdata_o = cmp_q[XLEN-1:0];
      if (sel.cmp_hi) csr_rdata_o = cmp_q[CMP_W-1 -: XLEN];
      if (sel.env_lo) csr_rdata_o = env_val[XLEN-1:0];
      if (sel.env_hi) csr_rdata_o = env_val[CMP_W-1 -: XLEN];
    end
  end

  AST_USER_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && owned && csr_priv_i == PRIV_U) |-> csr_illegal_o); // R7
  AST_SUP_NEEDS_TCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && csr_priv_i == PRIV_S && csr_addr_i == A_CMP_LO && !tce) |-> csr_illegal_o); // R7
  AST_ILLEGAL_KEEPS_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |=> $stable(cmp_q)); // R8
  AST_ILLEGAL_KEEPS_ENV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |=> $stable(env_val)); // R8
  AST_ILLEGAL_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |-> csr_rdata_o == '0); // R8
  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tce && cmp_q <= time_i) |=> sti_pend_o); // R5
  AST_PEND_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tce && cmp_q > time_i) |=> !sti_pend_o); // R5
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tce && !sti_sw_we_i) |=> $stable(sti_pend_o)); // R6
endmodule

// File: tb/stimer_cmp_test.sv
module stimer_cmp_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] tm = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wd = '0;
  logic [1:0]  priv = 2'd3;
  logic        cnt = 1'b1, swwe = 1'b0, swval = 1'b0;

  logic [63:0] rd64;
  logic [31:0] rd32;
  logic        ill64, ill32, pd64, pd32;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stimer_cmp #(.XLEN(64), .HAS_TCE(1'b1), .FIOM_WR(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .time_i(tm), .csr_req_i(req), .csr_we_i(we),
    .csr_addr_i(addr), .csr_wdata_i(wd), .csr_priv_i(priv), .tm_cnt_en_i(cnt),
    .sti_sw_we_i(swwe), .sti_sw_val_i(swval),
    .csr_rdata_o(rd64), .csr_illegal_o(ill64), .sti_pend_o(pd64));

  stimer_cmp #(.XLEN(32), .HAS_TCE(1'b1), .FIOM_WR(1'b0)) uut_n (
    .clk_i(clk), .rst_ni(rst_ni), .time_i(tm), .csr_req_i(req), .csr_we_i(we),
    .csr_addr_i(addr), .csr_wdata_i(wd[31:0]), .csr_priv_i(priv), .tm_cnt_en_i(cnt),
    .sti_sw_we_i(swwe), .sti_sw_val_i(swval),
    .csr_rdata_o(rd32), .csr_illegal_o(ill32), .sti_pend_o(pd32));

  // reference model: index 0 = 64-bit build, 1 = 32-bit build without fence bit
  logic [63:0] m_cmp [2] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF};
  bit m_tce [2] = '{0, 0};
  bit m_fiom[2] = '{0, 0};
  bit m_pend[2] = '{0, 0};

  function automatic bit is_cmp_addr(int k, logic [11:0] a);
    return a == 12'h14D || (k == 1 && a == 12'h15D);
  endfunction

  function automatic bit m_owned(int k, logic [11:0] a);
    return a == 12'h14D || a == 12'h30A || (k == 1 && (a == 12'h15D || a == 12'h31A));
  endfunction

  function automatic bit m_allow(int k);
    if (priv == 2'd3) return 1;
    if (priv == 2'd1) return is_cmp_addr(k, addr) && m_tce[k] && cnt;
    return 0;
  endfunction

  function automatic bit m_ill(int k);
    return req && m_owned(k, addr) && !m_allow(k);
  endfunction

  function automatic logic [63:0] m_read(int k);
    logic [63:0] env;
    env = {m_tce[k], 62'b0, m_fiom[k]};
    if (!(req && m_owned(k, addr) && m_allow(k))) return 64'd0;
    if (k == 0) return (addr == 12'h14D) ? m_cmp[0] : env;
    case (addr)
      12'h14D: return {32'b0, m_cmp[1][31:0]};
      12'h15D: return {32'b0, m_cmp[1][63:32]};
      12'h30A: return {32'b0, env[31:0]};
      default: return {32'b0, env[63:32]};
    endcase
  endfunction

  task automatic m_step(int k);
    if (!rst_ni) return;
    if (m_tce[k]) m_pend[k] = m_cmp[k] <= tm;
    else if (swwe) m_pend[k] = swval;
    if (req && we && m_owned(k, addr) && m_allow(k)) begin
      if (k == 0) begin
        if (addr == 12'h14D) m_cmp[0] = wd;
        else begin m_tce[0] = wd[63]; m_fiom[0] = wd[0]; end
      end else begin
        case (addr)
          12'h14D: m_cmp[1][31:0]  = wd[31:0];
          12'h15D: m_cmp[1][63:32] = wd[31:0];
          12'h30A: m_fiom[1] = 1'b0;
          default: m_tce[1] = wd[31];
        endcase
      end
    end
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string rd_tag(int k);
    if (!m_owned(k, addr)) return (addr == 12'h15D || addr == 12'h31A) ? "R9" : "R10";
    if (req && !m_allow(k)) return "R8";
    if (is_cmp_addr(k, addr)) return (k == 0) ? "R2" : "R3";
    return "R4";
  endfunction

  // compare against the model, then advance one clock
  task automatic cyc();
    #1;
    chk({rd_tag(0), " rdata64"}, rd64, m_read(0));
    chk({rd_tag(1), " rdata32"}, {32'b0, rd32}, m_read(1));
    chk("R7 illegal64", {63'b0, ill64}, {63'b0, m_ill(0)});
    chk("R7 illegal32", {63'b0, ill32}, {63'b0, m_ill(1)});
    chk(m_tce[0] ? "R5 pend64" : "R6 pend64", {63'b0, pd64}, {63'b0, m_pend[0]});
    chk(m_tce[1] ? "R5 pend32" : "R6 pend32", {63'b0, pd32}, {63'b0, m_pend[1]});
    @(posedge clk);
    m_step(0);
    m_step(1);
    @(negedge clk);
  endtask

  task automatic acc(logic [1:0] p, logic w, logic [11:0] a, logic [63:0] d);
    req = 1'b1; we = w; priv = p; addr = a; wd = d;
    cyc();
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [1:0] p, logic [11:0] a, logic [63:0] e64, logic [31:0] e32);
    req = 1'b1; we = 1'b0; priv = p; addr = a;
    #1;
    chk({tag, " read64"}, rd64, e64);
    chk({tag, " read32"}, {32'b0, rd32}, {32'b0, e32});
    cyc();
    req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    rd_chk("R1", 2'd3, 12'h14D, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF);
    rd_chk("R1", 2'd3, 12'h30A, 64'd0, 32'd0);
    chk("R1 pend64", {63'b0, pd64}, 64'd0);
    chk("R1 pend32", {63'b0, pd32}, 64'd0);
    rst_ni = 1'b1;
    tm = 64'd100;
    cyc();

    // R6 software load while disabled
    swwe = 1'b1; swval = 1'b1; cyc();
    swwe = 1'b0; cyc(); cyc();
    chk("R6 hold64", {63'b0, pd64}, 64'd1);
    chk("R6 hold32", {63'b0, pd32}, 64'd1);

    // R7 supervisor blocked while enable off
    req = 1'b1; priv = 2'd1; addr = 12'h14D; #1;
    chk("R7 s no tce 64", {63'b0, ill64}, 64'd1);
    chk("R7 s no tce 32", {63'b0, ill32}, 64'd1);
    cyc(); req = 1'b0;

    // R4 enable and fence bits
    acc(2'd3, 1'b1, 12'h30A, 64'h8000_0000_0000_0001);
    acc(2'd3, 1'b1, 12'h31A, 64'h0000_0000_8000_0000);
    rd_chk("R4", 2'd3, 12'h30A, 64'h8000_0000_0000_0001, 32'h0);
    rd_chk("R4", 2'd3, 12'h31A, 64'd0, 32'h8000_0000);

    // R2 / R3 compare writes
    acc(2'd3, 1'b1, 12'h14D, 64'd200);
    rd_chk("R3", 2'd3, 12'h15D, 64'd0, 32'hFFFF_FFFF);
    req = 1'b1; we = 1'b1; priv = 2'd3; addr = 12'h15D; wd = 64'd0; #1;
    chk("R9 unowned illegal64", {63'b0, ill64}, 64'd0);
    cyc(); req = 1'b0; we = 1'b0;
    rd_chk("R2", 2'd3, 12'h14D, 64'd200, 32'd200);

    // R5 time sweep across the compare value
    for (int t = 195; t <= 205; t++) begin
      tm = 64'(t);
      cyc();
    end
    chk("R5 due64", {63'b0, pd64}, 64'd1);
    chk("R5 due32", {63'b0, pd32}, 64'd1);
    acc(2'd3, 1'b1, 12'h14D, 64'd50);
    cyc();
    acc(2'd3, 1'b1, 12'h14D, 64'd1000);
    cyc();
    chk("R5 raised cmp 64", {63'b0, pd64}, 64'd0);
    chk("R5 raised cmp 32", {63'b0, pd32}, 64'd0);

    // R7 / R8 privilege rules
    cnt = 1'b0;
    acc(2'd1, 1'b1, 12'h14D, 64'd7);
    rd_chk("R8", 2'd3, 12'h14D, 64'd1000, 32'd1000);
    cnt = 1'b1;
    acc(2'd1, 1'b1, 12'h14D, 64'd150);
    acc(2'd1, 1'b1, 12'h30A, 64'd0);
    acc(2'd0, 1'b0, 12'h14D, 64'd0);
    acc(2'd2, 1'b1, 12'h14D, 64'd0);
    rd_chk("R8", 2'd3, 12'h30A, 64'h8000_0000_0000_0001, 32'h0);

    // R10 unowned address
    acc(2'd3, 1'b1, 12'h144, 64'hFFFF);
    cyc();

    // R6 software load ignored while enabled
    swwe = 1'b1; swval = 1'b0; cyc(); cyc();
    swwe = 1'b0;
    chk("R6 sw ignored 64", {63'b0, pd64}, 64'd1);
    chk("R6 sw ignored 32", {63'b0, pd32}, 64'd1);

    // disable: pending holds even when no longer due
    acc(2'd3, 1'b1, 12'h30A, 64'd0);
    acc(2'd3, 1'b1, 12'h31A, 64'd0);
    tm = 64'd0;
    cyc(); cyc();
    chk("R6 frozen64", {63'b0, pd64}, 64'd1);
    chk("R6 frozen32", {63'b0, pd32}, 64'd1);

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int sel;
      sel = $urandom_range(0, 9);
      req = ($urandom_range(0, 3) != 0);
      we = $urandom_range(0, 1);
      case ($urandom_range(0, 3))
        0: priv = 2'd0;
        1: priv = 2'd1;
        2: priv = 2'd2;
        default: priv = 2'd3;
      endcase
      if (sel < 5) begin
        addr = 12'h14D; wd = 64'($urandom_range(0, 300));
      end else if (sel == 5) begin
        addr = 12'h15D; wd = 64'($urandom_range(0, 1));
      end else if (sel == 6) begin
        addr = 12'h30A; wd = {$urandom, $urandom};
      end else if (sel == 7) begin
        addr = 12'h31A; wd = {$urandom, $urandom};
      end else begin
        addr = 12'h144; wd = {$urandom, $urandom};
      end
      cnt = ($urandom_range(0, 3) != 0);
      swwe = $urandom_range(0, 1);
      swval = $urandom_range(0, 1);
      tm = 64'($urandom_range(0, 300));
      cyc();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule